// File: doc/BRIEF.md
# Countdown Timer with Periodic Reload and Watchdog Role

This block is a memory-mapped down-counter. Software writes one word: the lower bits hold an interval and the top bit asks for automatic reload. Any write whose interval bits are non-zero starts counting down from that interval at once. A write whose interval bits are all zero stops the timer. When the count reaches zero the block emits a one-cycle pulse. With reload requested, it spends that one cycle at zero and then starts again from the stored interval, which gives a periodic tick of interval plus one cycles.

A parameter selects one of two roles at build time. In the periodic role the pulse appears on the interrupt output. In the watchdog role the top bit is ignored, there is never a reload, the interrupt output stays low, and the pulse appears on a reboot-request output. Software in that role keeps rewriting the count before it runs out.

The control is a three-state machine. `ST_IDLE` means stopped with a zero count. `ST_COUNT` means decrementing. `ST_EXPIRE` is the single cycle at zero. The transitions are:
- start: `ST_IDLE` to `ST_COUNT` on a non-zero write.
- halt: `ST_COUNT` or `ST_EXPIRE` to `ST_IDLE` on a zero write.
- reach_zero: `ST_COUNT` to `ST_EXPIRE` when the count is one and no write occurs.
- rearm: `ST_EXPIRE` to `ST_COUNT` when reload is set or a non-zero write arrives.
- retire: `ST_EXPIRE` to `ST_IDLE` with neither.

A non-zero write in `ST_COUNT` keeps the machine in `ST_COUNT` and reloads the count.

Top module: `cdt_timer`

## Requirements
- R1: After reset the read word is zero (count zero, reload flag clear) and neither pulse output is asserted until a write occurs.
- R2: A write whose bits 30:0 are non-zero makes the count equal that value on the next cycle. The count then drops by exactly one per cycle.
- R3: A write while the count is running replaces the count with the written value on the next cycle, and counting continues from there.
- R4: A write whose bits 30:0 are all zero stops the timer. The count becomes zero, the reload flag clears, and no pulse follows.
- R5: The output pulse is high for exactly one cycle: the cycle in which the count has just become zero.
- R6: In the periodic role, bit 31 of a non-zero write enables reload. After the zero cycle the count returns to the written interval, so pulses repeat every interval+1 cycles. Writing 0x8001387F gives pulses exactly 80000 cycles apart.
- R7: Without reload, after its pulse the timer stays stopped at zero.
- R8: In the watchdog role, bit 31 of a write is ignored and reads back as 0. There is no reload. The interrupt output never asserts. Expiry pulses the reboot-request output instead.
- R9: The read word carries the current count in bits 30:0 and the reload flag in bit 31.
- R10: A write during the zero cycle takes priority over reload: the next count is the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the timer word |
| wr_data | input | DATA_W | Written word: bit 31 reload request, bits 30:0 interval |
| rd_data | output | DATA_W | Reload flag in bit 31, current count in bits 30:0 |
| irq_o | output | 1 | One-cycle expiry pulse, periodic role only |
| wdog_rst_o | output | 1 | One-cycle reboot request, watchdog role only |

## Verification
The bench builds two instances at the default 32-bit word: one in the periodic role and one in the watchdog role. Both receive the same write sequence, so identical stimulus shows the top bit acting as a reload request in one role and being dropped in the other. The full word width makes the 0x8001387F interval reachable, so the 80000-cycle tick spacing is measured directly. Short intervals cover a write landing in the zero cycle and a write interrupting a running count.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EXPIRE = 2'd2
    } cdt_state_e;

    typedef enum logic {
        ROLE_PERIODIC = 1'b0,
        ROLE_WATCHDOG = 1'b1
    } cdt_role_e;

endpackage

// File: rtl/cdt_cfg.sv
module cdt_cfg
    import cdt_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter cdt_role_e ROLE   = ROLE_PERIODIC,
    localparam int       CNT_W  = DATA_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_flag,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] interval,
    output logic             reload_en
);

    logic wr_nz;
    assign wr_nz = |wr_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval <= '0;
        end else if (wr_en) begin
            interval <= wr_val;
        end
    end

    generate
        if (ROLE == ROLE_PERIODIC) begin : g_reload
            logic flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (wr_en) begin
                    flag_q <= wr_flag & wr_nz;
                end
            end
            assign reload_en = flag_q;

            AST_FLAG_NEEDS_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
                reload_en |-> (interval != '0)); // R4
        end else begin : g_noreload
            logic unused_flag;
            assign unused_flag = wr_flag;
            assign reload_en   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm
    import cdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_nz,
    input  logic       cnt_is_one,
    input  logic       reload_en,
    output cdt_state_e state,
    output logic       expire
);

    cdt_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_en && wr_nz) state_d = ST_COUNT;   // start
            end
            ST_COUNT: begin
                if (wr_en)           state_d = wr_nz ? ST_COUNT : ST_IDLE; // reload count / halt
                else if (cnt_is_one) state_d = ST_EXPIRE;                  // reach_zero
            end
            ST_EXPIRE: begin
                if (wr_en)          state_d = wr_nz ? ST_COUNT : ST_IDLE;  // rearm / halt
                else if (reload_en) state_d = ST_COUNT;                    // rearm
                else                state_d = ST_IDLE;                     // retire
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        expire = (state == ST_EXPIRE);
    end

    AST_EXPIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRE) |=> (state != ST_EXPIRE)); // R5

    AST_ZERO_WRITE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_nz) |=> (state == ST_IDLE)); // R4

endmodule

// File: rtl/cdt_count.sv
module cdt_count
    import cdt_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  cdt_state_e       state,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_is_one
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else begin
            unique case (state)
                ST_COUNT:  cnt <= cnt - ONE;
                ST_EXPIRE: cnt <= reload_en ? interval : '0;
                default:   cnt <= '0;
            endcase
        end
    end

    assign cnt_is_one = (cnt == ONE);

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wr_val))); // R3

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !wr_en) |=> (cnt == $past(cnt) - ONE)); // R2

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0)); // R7

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter cdt_role_e ROLE   = ROLE_PERIODIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    localparam int CNT_W = DATA_W - 1;

    logic [CNT_W-1:0] wr_val;
    logic             wr_flag;
    logic             wr_nz;
    logic [CNT_W-1:0] interval;
    logic             reload_en;
    logic [CNT_W-1:0] cnt;
    logic             cnt_is_one;
    logic             expire;
    cdt_state_e       state;

    assign wr_val  = wr_data[CNT_W-1:0];
    assign wr_flag = wr_data[DATA_W-1];
    assign wr_nz   = |wr_val;

    cdt_cfg #(.DATA_W(DATA_W), .ROLE(ROLE)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_flag   (wr_flag),
        .wr_val    (wr_val),
        .interval  (interval),
        .reload_en (reload_en)
    );

    cdt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_nz      (wr_nz),
        .cnt_is_one (cnt_is_one),
        .reload_en  (reload_en),
        .state      (state),
        .expire     (expire)
    );

    cdt_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .state      (state),
        .reload_en  (reload_en),
        .interval   (interval),
        .cnt        (cnt),
        .cnt_is_one (cnt_is_one)
    );

    assign rd_data = {reload_en, cnt};

    generate
        if (ROLE == ROLE_PERIODIC) begin : g_irq
            assign irq_o      = expire;
            assign wdog_rst_o = 1'b0;
        end else begin : g_wdog
            assign irq_o      = 1'b0;
            assign wdog_rst_o = expire;
        end
    endgenerate

    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || wdog_rst_o) |-> (rd_data[CNT_W-1:0] == '0)); // R5

    AST_PULSE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || wdog_rst_o) |-> ($past(rd_data[CNT_W-1:0]) == CNT_W'(1) && !$past(wr_en))); // R5

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && wdog_rst_o)); // R8

endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
    import cdt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int WATCHDOG_CYCLES = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_p, rd_w;
    logic          irq_p, rst_p, irq_w, rst_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdt_timer #(.DATA_W(DW), .ROLE(ROLE_PERIODIC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_p), .irq_o(irq_p), .wdog_rst_o(rst_p));

    cdt_timer #(.DATA_W(DW), .ROLE(ROLE_WATCHDOG)) u_dut_wd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_w), .irq_o(irq_w), .wdog_rst_o(rst_w));

    // behavioural reference, index 0 periodic, index 1 watchdog
    longint m_cnt [2];
    longint m_int [2];
    bit     m_rel [2];
    bit     m_run [2];
    bit     m_pls [2];

    int     n_vec = 0;
    int     n_bad = 0;
    string  cur_req = "R1";
    longint cyc = 0;
    longint last_irq = -1;
    int     n_irq = 0;
    int     n_wd = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int r = 0; r < 2; r++) begin
            if (!rst_n) begin
                m_cnt[r] = 0; m_int[r] = 0; m_rel[r] = 0; m_run[r] = 0; m_pls[r] = 0;
            end else if (wr_en) begin
                longint v;
                v = longint'(wr_data[DW-2:0]);
                if (v != 0) begin
                    m_cnt[r] = v; m_int[r] = v; m_run[r] = 1;
                    m_rel[r] = (r == 0) ? wr_data[DW-1] : 1'b0;
                end else begin
                    m_cnt[r] = 0; m_int[r] = 0; m_run[r] = 0; m_rel[r] = 0;
                end
                m_pls[r] = 0;
            end else if (m_pls[r]) begin
                m_pls[r] = 0;
                if (m_rel[r]) m_cnt[r] = m_int[r];
                else          m_run[r] = 0;
            end else if (m_run[r]) begin
                m_cnt[r] = m_cnt[r] - 1;
                if (m_cnt[r] == 0) m_pls[r] = 1;
            end
        end
    end

    task automatic cmp(input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("periodic read", longint'(rd_p), (longint'(m_rel[0]) << 31) | m_cnt[0]);
            cmp("periodic irq", longint'(irq_p), longint'(m_pls[0]));
            cmp("periodic reboot", longint'(rst_p), 0);
            cmp("watchdog read", longint'(rd_w), (longint'(m_rel[1]) << 31) | m_cnt[1]);
            cmp("watchdog irq", longint'(irq_w), 0);
            cmp("watchdog reboot", longint'(rst_w), longint'(m_pls[1]));
            if (irq_p) begin
                n_irq++;
                if (cur_req == "R6" && last_irq >= 0)
                    cmp("R6 tick spacing", cyc - last_irq, 80000);
                last_irq = cyc;
            end
            if (rst_w) n_wd++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [DW-1:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: bench did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state visible at ports
        cmp("R1 reset read periodic", longint'(rd_p), 0);
        cmp("R1 reset read watchdog", longint'(rd_w), 0);
        rst_n = 1'b1;
        cur_req = "R1"; idle(4);

        cur_req = "R2";  wr(32'd5);              // R2 R5 R7 R9
        cur_req = "R7";  idle(10);
        cur_req = "R8";  wr(32'h8000_0003);      // R6 in periodic, R8 in watchdog
        cmp("R9 flag bit periodic", longint'(rd_p[31]), 1);
        cmp("R8 flag bit watchdog", longint'(rd_w[31]), 0);
        idle(14);
        cur_req = "R3";  wr(32'h8000_0009); idle(3); wr(32'd12); idle(4);
        cur_req = "R4";  wr(32'h8000_0000); idle(6);
        cmp("R4 stopped periodic", longint'(rd_p), 0);
        cur_req = "R3";  wr(32'h8000_0006); idle(2); wr(32'h0000_0000); idle(4);
        cur_req = "R10"; wr(32'h8000_0002); idle(2); wr(32'd7); idle(12);
        cur_req = "R5";  wr(32'd1); idle(4);
        cur_req = "R6";  last_irq = -1; n_irq = 0; n_wd = 0;
        wr(32'h8001_387F);
        idle(160010);
        cmp("R6 tick count", longint'(n_irq), 2);
        cmp("R8 watchdog expiries", longint'(n_wd), 1);
        cur_req = "R4";  wr(32'd0); idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule